// File: doc/BRIEF.md
# Timestamp Event Capture and Interrupt Unit

This block sits beside a free-running 64-bit nanosecond time counter and turns asynchronous and synchronous happenings into latched events. Two external trigger pins are synchronized, edge-detected on a programmable edge, and each detected edge stores the current time into that trigger's own 64-bit timestamp register. Two alarm comparators watch the time and flag an event in the cycle after the time equals a programmed 64-bit value. Three periodic pulse strobes, produced elsewhere, also set event bits.

All events collect in one sticky event register. Software acknowledges events by writing ones, and several events can be cleared with one write. A mask register with the same bit layout selects which pending events drive the single interrupt line. Two alarm pins reflect the alarm event bits, each with a programmable active level. Registers are reached through a plain single-cycle register port. Writes take effect at the clock edge that samples them, and read data is a combinational function of the address. The port has no back-pressure: each access completes in the cycle it is presented.

Top module: `tsu_event_unit`

## Requirements
- R1: After reset the control, event and mask registers and both timestamp registers read zero, both alarm values read all ones, `irq` is low and both alarm pins are low.
- R2: Trigger 1 sets event bit 24 and trigger 2 sets event bit 25. Control bit 8 (trigger 1) and bit 9 (trigger 2) select the edge: 0 rising, 1 falling. A pin change sampled at clock edge E0 is detected between E1 and E2. At E2 the event bit is set and the timestamp takes the `time_ns` value presented between E1 and E2.
- R3: An edge of the non-selected direction sets no event bit and leaves the timestamp unchanged.
- R4: A capture while the trigger's event bit is still set overwrites the timestamp with the new time, and the bit stays set.
- R5: Alarm 1 sets event bit 16 and alarm 2 sets event bit 17. The bit is set at the clock edge that ends the cycle in which `time_ns` equals the alarm value. No bit is set before that cycle.
- R6: A high `pulse_in[0]`, `pulse_in[1]` or `pulse_in[2]` sets event bit 7, 6 or 5 respectively.
- R7: A write to the event register clears every bit written as 1 and leaves bits written as 0 unchanged.
- R8: When a source sets a bit in the same cycle that a write clears it, the bit ends set.
- R9: `irq` is high exactly when some event bit and the mask bit at the same position are both set.
- R10: `alarm_out[0]` equals event bit 16 XOR control bit 31, and `alarm_out[1]` equals event bit 17 XOR control bit 30.
- R11: Word addresses are: 0 control, 1 event, 2 mask, 4/5 alarm 1 high/low, 6/7 alarm 2 high/low, 8/9 trigger 1 timestamp high/low, and 10/11 trigger 2 timestamp high/low. Control keeps only bits 31, 30, 9 and 8. Event and mask keep only bits 25, 24, 17, 16, 7, 6 and 5. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_ns | input | 64 | Current time from the counter |
| trig_in | input | 2 | External trigger pins (asynchronous) |
| pulse_in | input | 3 | Periodic pulse strobes, one cycle each |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write when high with select |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Masked interrupt |
| alarm_out | output | 2 | Alarm pins with programmable level |

## Verification
A stuck or lost event bit shows at once on the event register read and on `irq` in the cycle after the source fires. Faults in the synchronizer or in the edge selection shift the capture by one or more cycles, or drop it, and the bench compares the timestamp against the time it presented in the detection cycle. Faults in the acknowledge logic leave bits set, or clear neighbouring bits, on the read that follows the write. An off-by-one compare or a partially written alarm shows as an event one cycle early or late around the matching time.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  // event bit positions (decoded by software, so fixed)
  localparam int TRIG_EV_LSB   = 24;
  localparam int ALARM_EV_LSB  = 16;
  localparam int PULSE_EV_MSB  = 7;
  // control bit positions
  localparam int TRIG_POL_LSB  = 8;
  localparam int ALARM_POL_MSB = 31;

  // word address map
  localparam int ADR_CTRL    = 0;
  localparam int ADR_EVENT   = 1;
  localparam int ADR_MASK    = 2;
  localparam int ADR_ALM_HI0 = 4;  // alarm k high at 4+2k, low at 5+2k
  localparam int ADR_TS_HI0  = 8;  // trigger k high at 8+2k, low at 9+2k

  function automatic logic [31:0] ev_impl(input int n_trig, input int n_alarm, input int n_pulse);
    logic [31:0] m;
    m = '0;
    for (int k = 0; k < n_trig; k++)  m[TRIG_EV_LSB + k]  = 1'b1;
    for (int k = 0; k < n_alarm; k++) m[ALARM_EV_LSB + k] = 1'b1;
    for (int k = 0; k < n_pulse; k++) m[PULSE_EV_MSB - k] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] ctrl_impl(input int n_trig, input int n_alarm);
    logic [31:0] m;
    m = '0;
    for (int k = 0; k < n_trig; k++)  m[TRIG_POL_LSB + k]  = 1'b1;
    for (int k = 0; k < n_alarm; k++) m[ALARM_POL_MSB - k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tsu_trig_capture.sv
module tsu_trig_capture #(
  parameter int TW          = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic          pol_fall,
  input  logic [TW-1:0] time_ns,
  output logic          fire,
  output logic [TW-1:0] stamp
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   lvl;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end
  endgenerate

  assign lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= lvl;

  // edge of the selected direction
  assign fire = pol_fall ? (last_q & ~lvl) : (lvl & ~last_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    stamp <= '0;
    else if (fire) stamp <= time_ns;
endmodule

// File: rtl/tsu_alarm_cmp.sv
module tsu_alarm_cmp #(
  parameter int TW = 64,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [DW-1:0] wdata,
  input  logic [TW-1:0] time_ns,
  output logic [TW-1:0] target,
  output logic          hit
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) target <= '1;
    else begin
      if (wr_hi) target[TW-1:DW] <= wdata[TW-DW-1:0];
      if (wr_lo) target[DW-1:0]  <= wdata;
    end

  assign hit = (time_ns == target);
endmodule

// File: rtl/tsu_event_reg.sv
module tsu_event_reg #(
  parameter int          DW      = 32,
  parameter logic [31:0] IMPL    = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic          ev_wr,
  input  logic          mask_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ev_q,
  output logic [DW-1:0] mask_q,
  output logic          irq
);
  logic [DW-1:0] ack;

  assign ack = ev_wr ? wdata : '0;

  // source set takes priority over acknowledge
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ((ev_q & ~ack) | set_vec) & IMPL[DW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= wdata & IMPL[DW-1:0];

  assign irq = |(ev_q & mask_q);
endmodule

// File: rtl/tsu_event_unit.sv
module tsu_event_unit
  import tsu_pkg::*;
#(
  parameter int TW          = 64,
  parameter int DW          = 32,
  parameter int AW          = 4,
  parameter int N_TRIG      = 2,
  parameter int N_ALARM     = 2,
  parameter int N_PULSE     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TW-1:0]      time_ns,
  input  logic [N_TRIG-1:0]  trig_in,
  input  logic [N_PULSE-1:0] pulse_in,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               irq,
  output logic [N_ALARM-1:0] alarm_out
);
  localparam logic [31:0] EV_IMPL   = ev_impl(N_TRIG, N_ALARM, N_PULSE);
  localparam logic [31:0] CTRL_IMPL = ctrl_impl(N_TRIG, N_ALARM);

  logic                wr_en;
  logic                ctrl_wr, ev_wr, mask_wr;
  logic [DW-1:0]       ctrl_q;
  logic [DW-1:0]       ev_q, mask_q;
  logic [DW-1:0]       set_vec;
  logic [N_TRIG-1:0]   trig_fire;
  logic [N_ALARM-1:0]  alarm_hit;
  logic [TW-1:0]       stamp  [N_TRIG];
  logic [TW-1:0]       target [N_ALARM];

  assign wr_en   = bus_sel & bus_wr;
  assign ctrl_wr = wr_en && (bus_addr == AW'(ADR_CTRL));
  assign ev_wr   = wr_en && (bus_addr == AW'(ADR_EVENT));
  assign mask_wr = wr_en && (bus_addr == AW'(ADR_MASK));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_IMPL[DW-1:0];

  genvar k;
  generate
    for (k = 0; k < N_TRIG; k++) begin : g_trig
      tsu_trig_capture #(.TW(TW), .SYNC_STAGES(SYNC_STAGES)) cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (trig_in[k]),
        .pol_fall (ctrl_q[TRIG_POL_LSB + k]),
        .time_ns  (time_ns),
        .fire     (trig_fire[k]),
        .stamp    (stamp[k])
      );
    end

    for (k = 0; k < N_ALARM; k++) begin : g_alarm
      logic hi_wr, lo_wr;
      assign hi_wr = wr_en && (bus_addr == AW'(ADR_ALM_HI0 + 2*k));
      assign lo_wr = wr_en && (bus_addr == AW'(ADR_ALM_HI0 + 2*k + 1));
      tsu_alarm_cmp #(.TW(TW), .DW(DW)) cmp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hi   (hi_wr),
        .wr_lo   (lo_wr),
        .wdata   (bus_wdata),
        .time_ns (time_ns),
        .target  (target[k]),
        .hit     (alarm_hit[k])
      );
      assign alarm_out[k] = ev_q[ALARM_EV_LSB + k] ^ ctrl_q[ALARM_POL_MSB - k];
    end
  endgenerate

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < N_TRIG; i++)  set_vec[TRIG_EV_LSB + i]  = trig_fire[i];
    for (int i = 0; i < N_ALARM; i++) set_vec[ALARM_EV_LSB + i] = alarm_hit[i];
    for (int i = 0; i < N_PULSE; i++) set_vec[PULSE_EV_MSB - i] = pulse_in[i];
  end

  tsu_event_reg #(.DW(DW), .IMPL(EV_IMPL)) evr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .ev_wr   (ev_wr),
    .mask_wr (mask_wr),
    .wdata   (bus_wdata),
    .ev_q    (ev_q),
    .mask_q  (mask_q),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(ADR_CTRL))  bus_rdata = ctrl_q;
    if (bus_addr == AW'(ADR_EVENT)) bus_rdata = ev_q;
    if (bus_addr == AW'(ADR_MASK))  bus_rdata = mask_q;
    for (int i = 0; i < N_ALARM; i++) begin
      if (bus_addr == AW'(ADR_ALM_HI0 + 2*i))     bus_rdata = target[i][TW-1:DW];
      if (bus_addr == AW'(ADR_ALM_HI0 + 2*i + 1)) bus_rdata = target[i][DW-1:0];
    end
    for (int i = 0; i < N_TRIG; i++) begin
      if (bus_addr == AW'(ADR_TS_HI0 + 2*i))      bus_rdata = stamp[i][TW-1:DW];
      if (bus_addr == AW'(ADR_TS_HI0 + 2*i + 1))  bus_rdata = stamp[i][DW-1:0];
    end
  end
endmodule

// File: rtl/tsu_event_chk.sv
module tsu_event_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ev_q,
  input logic [31:0] mask_q,
  input logic        irq,
  input logic [1:0]  trig_fire,
  input logic [1:0]  alarm_hit,
  input logic        ev_wr,
  input logic [31:0] wdata
);
  assert_trig_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire[0] |=> ev_q[24]);

  assert_trig2_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire[1] |=> ev_q[25]);

  assert_pending_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q[24] && !(ev_wr && wdata[24]) |=> ev_q[24]);

  assert_alarm_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit[0] |=> ev_q[16]);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr && wdata[24] && !trig_fire[0] |=> !ev_q[24]);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr && wdata[17] && alarm_hit[1] |=> ev_q[17]);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 32'd0) |-> !irq);
endmodule

bind tsu_event_unit tsu_event_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_q      (ev_q),
  .mask_q    (mask_q),
  .irq       (irq),
  .trig_fire (trig_fire),
  .alarm_hit (alarm_hit),
  .ev_wr     (ev_wr),
  .wdata     (bus_wdata)
);

// File: tb/tsu_event_unit_tb.sv
`timescale 1ns/1ps
module tsu_event_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] T0 = 64'h0000_0001_FFFF_FF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tnow;
  logic [1:0]  trig_in = '0;
  logic [2:0]  pulse_in = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [1:0]  alarm_out;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tnow <= T0;
    else        tnow <= tnow + 64'd1;

  tsu_event_unit dut_i (
    .clk(clk), .rst_n(rst_n), .time_ns(tnow), .trig_in(trig_in),
    .pulse_in(pulse_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .alarm_out(alarm_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic peek64(input logic [3:0] a_hi, output logic [63:0] d);
    logic [31:0] h, l;
    peek(a_hi, h);
    peek(a_hi + 4'd1, l);
    d = {h, l};
  endtask

  // drive the pin at a falling edge, return the time seen in the detection cycle
  task automatic edge_and_capture(input int idx, input logic lvl, output logic [63:0] t_det);
    @(negedge clk);
    trig_in[idx] = lvl;
    @(negedge clk);
    @(negedge clk);
    t_det = tnow;
    @(negedge clk);
  endtask

  logic [63:0] ts1_saved;

  task automatic t_reset;
    logic [31:0] d;
    logic [63:0] q;
    peek(4'd0, d);  chk("R1 ctrl", d, 0);
    peek(4'd1, d);  chk("R1 event", d, 0);
    peek(4'd2, d);  chk("R1 mask", d, 0);
    peek64(4'd4, q); chk("R1 alarm1", q, '1);
    peek64(4'd6, q); chk("R1 alarm2", q, '1);
    peek64(4'd8, q); chk("R1 ts1", q, 0);
    peek64(4'd10, q); chk("R1 ts2", q, 0);
    chk("R1 irq", irq, 0);
    chk("R1 alarm pins", alarm_out, 0);
  endtask

  task automatic t_trig_rise;
    logic [63:0] exp, q;
    logic [31:0] d;
    edge_and_capture(0, 1'b1, exp);
    peek(4'd1, d);   chk("R2 trig1 event bit24", d, 32'h0100_0000);
    peek64(4'd8, q); chk("R2 trig1 stamp", q, exp);
    ts1_saved = exp;
  endtask

  task automatic t_trig_ignore;
    logic [63:0] q;
    logic [31:0] d;
    wr(4'd1, 32'h0100_0000);
    trig_in[0] = 1'b0;
    repeat (5) @(negedge clk);
    peek(4'd1, d);   chk("R3 falling ignored event", d, 0);
    peek64(4'd8, q); chk("R3 falling ignored stamp", q, ts1_saved);
  endtask

  task automatic t_trig_fall_pol;
    logic [63:0] exp, q;
    logic [31:0] d;
    wr(4'd0, 32'h0000_0100);
    peek(4'd0, d); chk("R11 ctrl readback", d, 32'h0000_0100);
    trig_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    peek(4'd1, d); chk("R3 rising ignored in falling mode", d, 0);
    edge_and_capture(0, 1'b0, exp);
    peek(4'd1, d);   chk("R2 falling capture event", d, 32'h0100_0000);
    peek64(4'd8, q); chk("R2 falling capture stamp", q, exp);
    wr(4'd0, 32'h0);
    wr(4'd1, 32'h0100_0000);
  endtask

  task automatic t_recapture;
    logic [63:0] e1, e2, q;
    logic [31:0] d;
    edge_and_capture(1, 1'b1, e1);
    peek64(4'd10, q); chk("R2 trig2 stamp", q, e1);
    edge_and_capture(1, 1'b0, e2);
    peek64(4'd10, q); chk("R3 trig2 falling ignored", q, e1);
    edge_and_capture(1, 1'b1, e2);
    peek(4'd1, d);    chk("R4 bit25 stays set", d, 32'h0200_0000);
    peek64(4'd10, q); chk("R4 stamp overwritten", q, e2);
    wr(4'd1, 32'h0200_0000);
  endtask

  task automatic t_pulses;
    logic [31:0] d;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); pulse_in = 3'b001 << i;
      @(negedge clk); pulse_in = '0;
      peek(4'd1, d); chk("R6 pulse bit", d[7:5], 3'b111 << (2 - i) & 3'b111);
    end
    peek(4'd1, d); chk("R6 all pulse bits", d, 32'h0000_00E0);
    wr(4'd1, 32'h0000_0040);
    peek(4'd1, d); chk("R7 single ack keeps others", d, 32'h0000_00A0);
    wr(4'd1, 32'h0000_00A0);
    peek(4'd1, d); chk("R7 multi ack", d, 0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    @(negedge clk);
    pulse_in = 3'b100;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 32'h0000_0020;
    @(negedge clk);
    pulse_in = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    peek(4'd1, d); chk("R8 set beats ack", d, 32'h0000_0020);
    wr(4'd1, 32'h0000_0020);
    peek(4'd1, d); chk("R7 ack after set", d, 0);
  endtask

  task automatic t_alarm;
    logic [63:0] tgt;
    logic [31:0] d;
    @(negedge clk);
    tgt = tnow + 64'd20;
    wr(4'd4, tgt[63:32]);
    wr(4'd5, tgt[31:0]);
    while (tnow != tgt) @(negedge clk);
    peek(4'd1, d); chk("R5 no alarm before match", d, 0);
    chk("R10 pin idle", alarm_out[0], 1'b0);
    @(negedge clk);
    peek(4'd1, d); chk("R5 alarm1 bit16", d, 32'h0001_0000);
    chk("R10 pin active high", alarm_out[0], 1'b1);
    wr(4'd0, 32'h8000_0000);
    chk("R10 pin inverted", alarm_out[0], 1'b0);
    wr(4'd1, 32'h0001_0000);
    chk("R10 inverted idle", alarm_out[0], 1'b1);
    chk("R10 pin2 untouched", alarm_out[1], 1'b0);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    @(negedge clk); pulse_in = 3'b001;
    @(negedge clk); pulse_in = '0;
    chk("R9 masked off", irq, 0);
    wr(4'd2, 32'h0000_0080);
    chk("R9 enabled", irq, 1);
    wr(4'd2, 32'h0000_0040);
    chk("R9 other bit only", irq, 0);
    wr(4'd2, 32'hFFFF_FFFF);
    peek(4'd2, d); chk("R11 mask implemented bits", d, 32'h0303_00E0);
    chk("R9 all enabled", irq, 1);
    wr(4'd1, 32'h0000_0080);
    chk("R9 cleared", irq, 0);
    wr(4'd0, 32'hFFFF_FFFF);
    peek(4'd0, d); chk("R11 ctrl implemented bits", d, 32'hC000_0300);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_trig_rise();
    t_trig_ignore();
    t_trig_fall_pol();
    t_recapture();
    t_pulses();
    t_set_wins();
    t_alarm();
    t_irq();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule